// File: doc/BRIEF.md
# Memory Capsule Access Checker

This block stands between address translation and the memory crypto path. Software is split into memory capsules. A capsule is a protected region that holds code, a private heap and a private stack, or a region of data that several capsules share. Each capsule has one attribute entry in a small table. The entry holds the capsule's owner ID, its control bits, a key selector and a signature selector.

For every load, store or instruction fetch, the translation hit supplies the table index of the target page. The checker compares the ID of the capsule now executing with the owner of the target capsule, and takes into account the access kind and whether the fetch comes from a call. One clock after the request it answers with either grant or fault. On a grant it also returns the entry's key selector and signature selector for the downstream decryption and authentication logic. A separate write port programs table entries.

Top module: `capsule_access_guard`

## Requirements
- R1: Reset behaviour.
  - While reset is held, and after it is released, all response outputs are 0.
  - Every table entry is invalid, so any access made before its entry is programmed faults.
- R2: Latency.
  - A request accepted on a rising edge (`req_valid`=1) produces exactly one response with `rsp_valid`=1 after that same edge.
  - When no request was accepted on an edge, `rsp_valid` is 0 after that edge.
- R3: An access whose `active_id` equals the owner ID of a valid target entry is granted. This holds for load, store and fetch alike.
- R4: A load or a store from a foreign capsule to a valid entry that is not marked shared faults.
- R5: A fetch from a foreign capsule is granted only when `req_is_call` is 1. A plain fetch into a foreign capsule faults, whether or not that capsule is shared.
- R6: Foreign access to a shared capsule.
  - A foreign load from a valid shared entry (control bit 1 set) is granted.
  - A foreign store to it is granted only when the shared-write bit (control bit 2) is also set. Otherwise the store faults.
- R7: Invalid entries and the reserved kind.
  - An access to an entry whose valid bit (control bit 0) is clear faults.
  - A request of the reserved kind code 2'b11 faults, even from the owner.
  - The kind codes are 2'b00 load, 2'b01 store and 2'b10 fetch.
- R8: Response outputs.
  - A valid response asserts exactly one of `rsp_grant` and `rsp_fault`.
  - On a grant, `rsp_key_sel` and `rsp_sig_sel` equal the selectors of the target entry.
  - On a fault, both selectors are 0.
- R9: Programming and lookup in the same cycle.
  - When an entry is programmed on the same edge as a lookup to it, that lookup uses the entry's old contents.
  - A lookup on the following edge sees the new contents.
- R10: Programming one entry leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en | input | 1 | Write one table entry on this edge |
| prog_idx | input | IDX_W | Entry to write |
| prog_owner | input | ID_W | Owner capsule ID for the entry |
| prog_ctrl | input | 3 | Control bits: bit0 valid, bit1 shared, bit2 shared-write |
| prog_key | input | KEY_W | Key selector for the entry |
| prog_sig | input | SIG_W | Signature selector for the entry |
| req_valid | input | 1 | An access is presented this cycle |
| req_idx | input | IDX_W | Table index from the translation hit |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 reserved |
| req_is_call | input | 1 | The fetch is the target of a call instruction |
| active_id | input | ID_W | Capsule ID of the executing principal |
| rsp_valid | output | 1 | A decision is present |
| rsp_grant | output | 1 | The access is allowed |
| rsp_fault | output | 1 | The access is refused |
| rsp_key_sel | output | KEY_W | Key selector on a grant, else 0 |
| rsp_sig_sel | output | SIG_W | Signature selector on a grant, else 0 |

## Verification
The table is the only long-lived state, so a corrupted owner, control or selector field shows up at the first later lookup to that entry. That lookup can show the wrong grant or fault value, or selectors that do not belong to the entry, one cycle after the request. The bench therefore looks up each programmed entry from its owner and from a foreign capsule, and looks up a neighbouring entry again after a write to check that nothing else moved. A response register that stalls or duplicates shows at once as a missing response or an unexpected one, in the cycle after the request.

// File: rtl/cap_guard_pkg.sv
package cap_guard_pkg;

    localparam int CTRL_W       = 3;
    localparam int CTRL_VALID   = 0;
    localparam int CTRL_SHARED  = 1;
    localparam int CTRL_SHR_WR  = 2;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

endpackage

// File: rtl/cap_attr_table.sv
module cap_attr_table
    import cap_guard_pkg::*;
#(
    parameter int NUM_CAPS = 16,
    parameter int ID_W     = 8,
    parameter int KEY_W    = 6,
    parameter int SIG_W    = 10,
    localparam int IDX_W   = (NUM_CAPS > 1) ? $clog2(NUM_CAPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ID_W-1:0]   wr_owner,
    input  logic [CTRL_W-1:0] wr_ctrl,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [SIG_W-1:0]  wr_sig,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ID_W-1:0]   rd_owner,
    output logic [CTRL_W-1:0] rd_ctrl,
    output logic [KEY_W-1:0]  rd_key,
    output logic [SIG_W-1:0]  rd_sig
);

    typedef struct packed {
        logic [ID_W-1:0]   owner;
        logic [CTRL_W-1:0] ctrl;
        logic [KEY_W-1:0]  key;
        logic [SIG_W-1:0]  sig;
    } entry_t;

    localparam logic [IDX_W:0] DEPTH = NUM_CAPS[IDX_W:0];

    entry_t tab_d [NUM_CAPS];
    entry_t tab_q [NUM_CAPS];

    // Per-entry write decode: each entry owns its next-state logic.
    for (genvar gi = 0; gi < NUM_CAPS; gi++) begin : g_entry
        always_comb begin
            tab_d[gi] = tab_q[gi];
            if (wr_en && (wr_idx == IDX_W'(gi))) begin
                tab_d[gi].owner = wr_owner;
                tab_d[gi].ctrl  = wr_ctrl;
                tab_d[gi].key   = wr_key;
                tab_d[gi].sig   = wr_sig;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tab_q[gi] <= '0;
            end else begin
                tab_q[gi] <= tab_d[gi];
            end
        end
    end

    // Read from registered state: a same-edge write is not visible yet.
    entry_t rd_ent;
    always_comb begin
        rd_ent = '0;
        if ({1'b0, rd_idx} < DEPTH) begin
            rd_ent = tab_q[rd_idx];
        end
    end

    assign rd_owner = rd_ent.owner;
    assign rd_ctrl  = rd_ent.ctrl;
    assign rd_key   = rd_ent.key;
    assign rd_sig   = rd_ent.sig;

endmodule

// File: rtl/cap_perm_decide.sv
module cap_perm_decide
    import cap_guard_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic [ID_W-1:0]   active_id,
    input  logic [ID_W-1:0]   ent_owner,
    input  logic [CTRL_W-1:0] ent_ctrl,
    input  logic [1:0]        kind,
    input  logic              is_call,
    output logic              allow
);

    logic ent_valid;
    logic ent_shared;
    logic ent_shr_wr;
    logic same_cap;

    assign ent_valid  = ent_ctrl[CTRL_VALID];
    assign ent_shared = ent_ctrl[CTRL_SHARED];
    assign ent_shr_wr = ent_ctrl[CTRL_SHR_WR];
    assign same_cap   = (active_id == ent_owner);

    always_comb begin
        allow = 1'b0;
        if (ent_valid) begin
            unique case (acc_kind_e'(kind))
                ACC_LOAD:  allow = same_cap || ent_shared;
                ACC_STORE: allow = same_cap || (ent_shared && ent_shr_wr);
                ACC_FETCH: allow = same_cap || is_call;
                ACC_RSVD:  allow = 1'b0;
                default:   allow = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/capsule_access_guard.sv
module capsule_access_guard
    import cap_guard_pkg::*;
#(
    parameter int NUM_CAPS = 16,
    parameter int ID_W     = 8,
    parameter int KEY_W    = 6,
    parameter int SIG_W    = 10,
    localparam int IDX_W   = (NUM_CAPS > 1) ? $clog2(NUM_CAPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [IDX_W-1:0]  prog_idx,
    input  logic [ID_W-1:0]   prog_owner,
    input  logic [2:0]        prog_ctrl,
    input  logic [KEY_W-1:0]  prog_key,
    input  logic [SIG_W-1:0]  prog_sig,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [1:0]        req_kind,
    input  logic              req_is_call,
    input  logic [ID_W-1:0]   active_id,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_fault,
    output logic [KEY_W-1:0]  rsp_key_sel,
    output logic [SIG_W-1:0]  rsp_sig_sel
);

    typedef struct packed {
        logic             valid;
        logic             grant;
        logic             fault;
        logic [KEY_W-1:0] key;
        logic [SIG_W-1:0] sig;
    } rsp_t;

    logic [ID_W-1:0]   lk_owner;
    logic [CTRL_W-1:0] lk_ctrl;
    logic [KEY_W-1:0]  lk_key;
    logic [SIG_W-1:0]  lk_sig;
    logic              lk_allow;

    cap_attr_table #(
        .NUM_CAPS (NUM_CAPS),
        .ID_W     (ID_W),
        .KEY_W    (KEY_W),
        .SIG_W    (SIG_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (prog_en),
        .wr_idx   (prog_idx),
        .wr_owner (prog_owner),
        .wr_ctrl  (prog_ctrl),
        .wr_key   (prog_key),
        .wr_sig   (prog_sig),
        .rd_idx   (req_idx),
        .rd_owner (lk_owner),
        .rd_ctrl  (lk_ctrl),
        .rd_key   (lk_key),
        .rd_sig   (lk_sig)
    );

    cap_perm_decide #(
        .ID_W (ID_W)
    ) u_decide (
        .active_id (active_id),
        .ent_owner (lk_owner),
        .ent_ctrl  (lk_ctrl),
        .kind      (req_kind),
        .is_call   (req_is_call),
        .allow     (lk_allow)
    );

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.grant = lk_allow;
            rsp_d.fault = !lk_allow;
            if (lk_allow) begin
                rsp_d.key = lk_key;
                rsp_d.sig = lk_sig;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_grant   = rsp_q.grant;
    assign rsp_fault   = rsp_q.fault;
    assign rsp_key_sel = rsp_q.key;
    assign rsp_sig_sel = rsp_q.sig;

endmodule

// File: rtl/cap_guard_chk.sv
module cap_guard_chk #(
    parameter int KEY_W = 6,
    parameter int SIG_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_kind,
    input logic             rsp_valid,
    input logic             rsp_grant,
    input logic             rsp_fault,
    input logic [KEY_W-1:0] rsp_key_sel,
    input logic [SIG_W-1:0] rsp_sig_sel
);

    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid)
        else $error("R2: request without response");

    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid)
        else $error("R2: response without request");

    a_r8_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_grant != rsp_fault))
        else $error("R8: grant and fault not exclusive");

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_grant && !rsp_fault))
        else $error("R8: verdict without valid");

    a_r8_fault_zero_sel: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_key_sel == '0 && rsp_sig_sel == '0))
        else $error("R8: selectors leaked on fault");

    a_r7_rsvd_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b11) |=> rsp_fault)
        else $error("R7: reserved kind not faulted");

endmodule

bind capsule_access_guard cap_guard_chk #(
    .KEY_W (KEY_W),
    .SIG_W (SIG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .rsp_valid   (rsp_valid),
    .rsp_grant   (rsp_grant),
    .rsp_fault   (rsp_fault),
    .rsp_key_sel (rsp_key_sel),
    .rsp_sig_sel (rsp_sig_sel)
);

// File: tb/capsule_access_guard_tb.sv
module capsule_access_guard_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCAP  = 16;
    localparam int IDXW  = 4;
    localparam int IDW   = 8;
    localparam int KW    = 6;
    localparam int SW    = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            prog_en = 1'b0;
    logic [IDXW-1:0] prog_idx = '0;
    logic [IDW-1:0]  prog_owner = '0;
    logic [2:0]      prog_ctrl = '0;
    logic [KW-1:0]   prog_key = '0;
    logic [SW-1:0]   prog_sig = '0;
    logic            req_valid = 1'b0;
    logic [IDXW-1:0] req_idx = '0;
    logic [1:0]      req_kind = '0;
    logic            req_is_call = 1'b0;
    logic [IDW-1:0]  active_id = '0;
    logic            rsp_valid, rsp_grant, rsp_fault;
    logic [KW-1:0]   rsp_key_sel;
    logic [SW-1:0]   rsp_sig_sel;

    capsule_access_guard #(
        .NUM_CAPS (NCAP), .ID_W (IDW), .KEY_W (KW), .SIG_W (SW)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .prog_en (prog_en), .prog_idx (prog_idx), .prog_owner (prog_owner),
        .prog_ctrl (prog_ctrl), .prog_key (prog_key), .prog_sig (prog_sig),
        .req_valid (req_valid), .req_idx (req_idx), .req_kind (req_kind),
        .req_is_call (req_is_call), .active_id (active_id),
        .rsp_valid (rsp_valid), .rsp_grant (rsp_grant), .rsp_fault (rsp_fault),
        .rsp_key_sel (rsp_key_sel), .rsp_sig_sel (rsp_sig_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Bench model of the table, built from the requirements.
    logic [IDW-1:0] m_owner [NCAP];
    logic [2:0]     m_ctrl  [NCAP];
    logic [KW-1:0]  m_key   [NCAP];
    logic [SW-1:0]  m_sig   [NCAP];

    typedef struct {
        int            at;
        logic          g;
        logic [KW-1:0] k;
        logic [SW-1:0] s;
        string         tag;
    } exp_t;

    exp_t sb[$];

    function automatic logic model_allow(int idx, logic [1:0] kind, logic call, logic [IDW-1:0] act);
        logic same;
        if (!m_ctrl[idx][0]) return 1'b0;
        same = (m_owner[idx] == act);
        case (kind)
            2'b00:   return same || m_ctrl[idx][1];
            2'b01:   return same || (m_ctrl[idx][1] && m_ctrl[idx][2]);
            2'b10:   return same || call;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(bit ok, string tag, string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s", tag, what);
        end
    endtask

    // Drive one request on this negedge and push its expectation.
    task automatic put_req(int idx, logic [1:0] kind, logic call, logic [IDW-1:0] act, string tag);
        exp_t e;
        req_valid   = 1'b1;
        req_idx     = IDXW'(idx);
        req_kind    = kind;
        req_is_call = call;
        active_id   = act;
        e.at  = cyc;
        e.g   = model_allow(idx, kind, call, act);
        e.k   = e.g ? m_key[idx] : '0;
        e.s   = e.g ? m_sig[idx] : '0;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic put_prog(int idx, logic [IDW-1:0] own, logic [2:0] ctl, logic [KW-1:0] k, logic [SW-1:0] s);
        prog_en    = 1'b1;
        prog_idx   = IDXW'(idx);
        prog_owner = own;
        prog_ctrl  = ctl;
        prog_key   = k;
        prog_sig   = s;
    endtask

    task automatic step();
        @(negedge clk);
        if (prog_en) begin
            m_owner[prog_idx] = prog_owner;
            m_ctrl[prog_idx]  = prog_ctrl;
            m_key[prog_idx]   = prog_key;
            m_sig[prog_idx]   = prog_sig;
        end
        prog_en   = 1'b0;
        req_valid = 1'b0;
    endtask

    task automatic req(int idx, logic [1:0] kind, logic call, logic [IDW-1:0] act, string tag);
        put_req(idx, kind, call, act, tag);
        step();
    endtask

    task automatic prog(int idx, logic [IDW-1:0] own, logic [2:0] ctl, logic [KW-1:0] k, logic [SW-1:0] s);
        put_prog(idx, own, ctl, k, s);
        step();
    endtask

    // Monitor: one response per request, in the cycle after it.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sb.size() > 0 && sb[0].at == cyc - 1) begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_valid === 1'b1, "R2", $sformatf("%s rsp_valid act=%b exp=1", e.tag, rsp_valid));
                check(rsp_grant === e.g && rsp_fault === !e.g, e.tag,
                      $sformatf("grant/fault act=%b/%b exp=%b/%b", rsp_grant, rsp_fault, e.g, !e.g));
                check(rsp_key_sel === e.k && rsp_sig_sel === e.s, "R8",
                      $sformatf("%s sel act=%h/%h exp=%h/%h", e.tag, rsp_key_sel, rsp_sig_sel, e.k, e.s));
            end else if (rsp_valid !== 1'b0) begin
                check(1'b0, "R2", $sformatf("spurious rsp_valid act=%b exp=0", rsp_valid));
            end
        end
    end

    initial begin
        for (int i = 0; i < NCAP; i++) begin
            m_owner[i] = '0; m_ctrl[i] = '0; m_key[i] = '0; m_sig[i] = '0;
        end
        repeat (3) @(negedge clk);
        check({rsp_valid, rsp_grant, rsp_fault, rsp_key_sel, rsp_sig_sel} == '0, "R1",
              $sformatf("outputs in reset act=%b%b%b exp=000", rsp_valid, rsp_grant, rsp_fault));
        rst_n = 1'b1;
        @(negedge clk);
        check({rsp_valid, rsp_grant, rsp_fault} == 3'b000, "R1",
              $sformatf("outputs after reset act=%b%b%b exp=000", rsp_valid, rsp_grant, rsp_fault));
        req(0, 2'b00, 1'b0, 8'h00, "R1");   // unprogrammed entry faults

        prog(1, 8'h11, 3'b001, 6'd5, 10'h021);
        prog(2, 8'h22, 3'b001, 6'd6, 10'h032);
        prog(3, 8'h33, 3'b011, 6'd7, 10'h043);
        prog(4, 8'h44, 3'b111, 6'd8, 10'h054);
        prog(5, 8'h55, 3'b000, 6'd9, 10'h065);

        req(1, 2'b00, 1'b0, 8'h11, "R3");
        req(1, 2'b01, 1'b0, 8'h11, "R3");
        req(1, 2'b10, 1'b0, 8'h11, "R3");
        req(2, 2'b00, 1'b0, 8'h11, "R4");
        req(2, 2'b01, 1'b1, 8'h11, "R4");
        step();
        req(2, 2'b10, 1'b1, 8'h11, "R5");
        req(2, 2'b10, 1'b0, 8'h11, "R5");
        req(3, 2'b10, 1'b0, 8'h11, "R5");
        req(3, 2'b00, 1'b0, 8'h11, "R6");
        req(3, 2'b01, 1'b0, 8'h11, "R6");
        req(4, 2'b00, 1'b0, 8'h22, "R6");
        req(4, 2'b01, 1'b0, 8'h22, "R6");
        req(3, 2'b00, 1'b0, 8'h22, "R6");
        req(5, 2'b00, 1'b0, 8'h55, "R7");
        req(1, 2'b11, 1'b0, 8'h11, "R7");
        step();

        // R9: program entry 2 to owner 0x11 while 0x11 loads from it.
        put_prog(2, 8'h11, 3'b001, 6'd12, 10'h3a1);
        put_req(2, 2'b00, 1'b0, 8'h11, "R9");
        step();
        req(2, 2'b00, 1'b0, 8'h11, "R9");
        req(1, 2'b00, 1'b0, 8'h11, "R10");
        req(3, 2'b00, 1'b0, 8'h22, "R10");
        req(1, 2'b00, 1'b0, 8'h22, "R10");
        step();
        step();
        check(sb.size() == 0, "R2", $sformatf("pending responses act=%0d exp=0", sb.size()));
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule